// File: doc/BRIEF.md
# Interleaved Video Stream Line Extractor

This block sits on an 8-bit digital video stream in which luma and chroma bytes are interleaved and one byte arrives per pixel clock. It watches for four-byte timing references, which are the preamble 0xFF, 0x00, 0x00 followed by a status byte. It checks the protection bits of each status byte and decodes three flags from it: field, vertical blanking and line-end. Each accepted code is reported on a one-cycle code strobe.

Between a start-of-line code and the matching end code, the block forwards only the payload bytes. Each forwarded byte carries its field, a line-start and line-end marker, a byte index and a component phase. Blanking filler and the reserved values 0x00 and 0xFF are never forwarded.

The block checks that every line carries exactly the configured number of bytes. If a line closes with any other count, or a new start code cuts it short, the block raises a one-cycle line-error pulse so that downstream logic can discard the line. It also keeps a running count of the active lines in the current field. A downstream frame assembler uses the field tag, the markers and the line count to place each line.

Top module: `vid_line_extract`

## Requirements
- R1: A status byte that follows the consecutive valid bytes 0xFF, 0x00, 0x00 is a timing code. When it passes R2, code_valid pulses in the cycle after the status byte is taken. In that cycle code_field carries status bit 6, code_vblank carries bit 5 and code_eol carries bit 4.
- R2: A timing code is accepted only when bit 7 is 1 and bits 3..0 equal {V^H, F^H, F^V, F^V^H}, where F = bit 6, V = bit 5 and H = bit 4. A code that fails this check pulses code_err one cycle later, changes no state, and is not forwarded.
- R3: An accepted code with H=0 and V=0 opens a line; 0x80 opens a field-0 line and 0xC7 opens a field-1 line. The bytes that follow are forwarded with out_field equal to F. A start code with V=1 opens no line, and nothing is forwarded after it. No payload is output in a cycle that reports a code.
- R4: No byte is forwarded while no line is open, so blanking filler such as 0x80 and 0x10 is never output. Inside a line, the bytes 0x00 and 0xFF are dropped and are not counted.
- R5: Forwarded bytes carry out_idx counting from 0 and out_phase equal to out_idx mod 4 (0 = Cb, 1 = Y, 2 = Cr, 3 = Y). out_sol is set on index 0 and out_eol on index LINE_BYTES-1. Each forwarded byte appears one cycle after it is taken.
- R6: Payload bytes beyond LINE_BYTES in one line are dropped.
- R7: An accepted code with H=1 closes an open line (0x9D in field 0, 0xDA in field 1). line_err pulses with the code strobe when the line held a number of counted bytes other than LINE_BYTES. An end code with no open line raises no error.
- R8: An accepted start code that arrives while a line is open pulses line_err with its code strobe. If the new code has V=0, it then opens a fresh line starting at index 0.
- R9: line_count is 0 after reset. It increments, saturating at MAX_LINES, on every accepted line-opening start code. It is cleared when an accepted code carries a field bit different from the previous accepted code, with the initial field taken as 0. A line-opening code that changes the field leaves line_count at 1.
- R10: A byte presented with in_valid low is ignored. It forms no part of a preamble, so a preamble split by idle cycles is still detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_byte holds a stream byte |
| in_byte | input | 8 | Stream byte |
| out_valid | output | 1 | Forwarded payload byte present |
| out_byte | output | 8 | Payload byte |
| out_field | output | 1 | Field of the line being forwarded |
| out_sol | output | 1 | First byte of the line |
| out_eol | output | 1 | Last expected byte of the line |
| out_idx | output | $clog2(LINE_BYTES) | Byte index within the line |
| out_phase | output | 2 | Component phase: 0 Cb, 1 Y, 2 Cr, 3 Y |
| code_valid | output | 1 | Accepted timing code strobe |
| code_field | output | 1 | Field bit of the code |
| code_vblank | output | 1 | Vertical-blanking bit of the code |
| code_eol | output | 1 | Line-end bit of the code |
| code_err | output | 1 | Protection-check failure strobe |
| line_err | output | 1 | Line length or truncation error strobe |
| line_count | output | $clog2(MAX_LINES+1) | Active lines in the current field |

## Verification
The bench is built with a 16-byte line. It sweeps the line length from zero to three bytes past nominal in both fields. At every length it checks that line_err fires only off nominal and that forwarding stops at the limit; a counter compared with the wrong bound, or one not cleared by the start code, fails this sweep.

Further cases target the quieter mistakes:
- A blanking start code: a design that ignored the V bit would forward bytes after it.
- A corrupted status byte: a design that skipped the protection check would open a line.
- A start code that truncates a line: a design would miss the error or continue the old index.
- Reserved bytes inside a line, and a preamble broken by idle cycles: these catch a design that counts 0x00 and 0xFF, or that shifts idle bytes into its preamble history.
- The first line-opening code of a new field: line_count must drop back to 1 on it.

// File: rtl/vle_pkg.sv
package vle_pkg;

    // Decoded flag bits of a timing status byte
    typedef struct packed {
        logic f;   // field
        logic v;   // vertical blanking
        logic h;   // 1 = line end code
    } vle_flags_t;

    // Expected protection nibble for given flags
    function automatic logic [3:0] vle_prot(input logic f, input logic v, input logic h);
        return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/vle_sync_detect.sv
module vle_sync_detect
    import vle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       code_ok,
    output logic       code_bad,
    output vle_flags_t flags
);

    typedef struct packed {
        logic [7:0] b0;   // newest valid byte
        logic [7:0] b1;
        logic [7:0] b2;   // oldest of the three
    } hist_t;

    hist_t hist_d, hist_q;
    logic  hit;

    always_comb begin
        hist_d = hist_q;
        if (in_valid) begin
            hist_d.b2 = hist_q.b1;
            hist_d.b1 = hist_q.b0;
            hist_d.b0 = in_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '{b0: 8'h55, b1: 8'h55, b2: 8'h55};
        end else begin
            hist_q <= hist_d;
        end
    end

    always_comb begin
        hit      = in_valid && (hist_q.b2 == 8'hFF) && (hist_q.b1 == 8'h00) && (hist_q.b0 == 8'h00);
        flags.f  = in_byte[6];
        flags.v  = in_byte[5];
        flags.h  = in_byte[4];
        code_ok  = hit && in_byte[7] && (in_byte[3:0] == vle_prot(in_byte[6], in_byte[5], in_byte[4]));
        code_bad = hit && !code_ok;
    end

endmodule

// File: rtl/vle_line_tracker.sv
module vle_line_tracker
    import vle_pkg::*;
#(
    parameter int LINE_BYTES = 1440,
    parameter int MAX_LINES  = 1023
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [7:0]                    in_byte,
    input  logic                          code_ok,
    input  logic                          code_bad,
    input  vle_flags_t                    flags,
    output logic                          out_valid,
    output logic [7:0]                    out_byte,
    output logic                          out_field,
    output logic                          out_sol,
    output logic                          out_eol,
    output logic [$clog2(LINE_BYTES)-1:0] out_idx,
    output logic [1:0]                    out_phase,
    output logic                          code_valid,
    output logic                          code_field,
    output logic                          code_vblank,
    output logic                          code_eol,
    output logic                          code_err,
    output logic                          line_err,
    output logic [$clog2(MAX_LINES+1)-1:0] line_count
);

    localparam int IDX_W = $clog2(LINE_BYTES);
    localparam int CNT_W = $clog2(LINE_BYTES + 2);
    localparam int LC_W  = $clog2(MAX_LINES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LINE_BYTES);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(LINE_BYTES + 1);
    localparam logic [LC_W-1:0]  LC_MAX   = LC_W'(MAX_LINES);

    typedef struct packed {
        logic             active;
        logic             line_field;
        logic [CNT_W-1:0] cnt;
        logic             last_field;
        logic [LC_W-1:0]  line_cnt;
        logic             o_valid;
        logic [7:0]       o_byte;
        logic             o_field;
        logic             o_sol;
        logic             o_eol;
        logic [IDX_W-1:0] o_idx;
        logic             c_valid;
        logic             c_f;
        logic             c_v;
        logic             c_h;
        logic             c_err;
        logic             l_err;
    } trk_t;

    trk_t            st_d, st_q;
    logic [LC_W-1:0] lc_base;
    logic            reserved;

    always_comb begin
        st_d         = st_q;
        st_d.o_valid = 1'b0;
        st_d.o_sol   = 1'b0;
        st_d.o_eol   = 1'b0;
        st_d.c_valid = 1'b0;
        st_d.c_err   = 1'b0;
        st_d.l_err   = 1'b0;
        lc_base      = st_q.line_cnt;
        reserved     = (in_byte == 8'h00) || (in_byte == 8'hFF);

        if (in_valid) begin
            if (code_ok) begin
                st_d.c_valid = 1'b1;
                st_d.c_f     = flags.f;
                st_d.c_v     = flags.v;
                st_d.c_h     = flags.h;
                if (flags.f != st_q.last_field) begin
                    st_d.last_field = flags.f;
                    lc_base         = '0;
                end
                st_d.line_cnt = lc_base;
                if (!flags.h) begin
                    // start code: any open line is cut short
                    st_d.l_err  = st_q.active;
                    st_d.active = !flags.v;
                    if (!flags.v) begin
                        st_d.line_field = flags.f;
                        st_d.cnt        = '0;
                        if (lc_base != LC_MAX) begin
                            st_d.line_cnt = lc_base + 1'b1;
                        end
                    end
                end else if (st_q.active) begin
                    st_d.l_err  = (st_q.cnt != CNT_FULL);
                    st_d.active = 1'b0;
                end
            end else if (code_bad) begin
                st_d.c_err = 1'b1;
            end else if (st_q.active && !reserved) begin
                if (st_q.cnt < CNT_FULL) begin
                    st_d.o_valid = 1'b1;
                    st_d.o_byte  = in_byte;
                    st_d.o_field = st_q.line_field;
                    st_d.o_idx   = st_q.cnt[IDX_W-1:0];
                    st_d.o_sol   = (st_q.cnt == '0);
                    st_d.o_eol   = (st_q.cnt == CNT_FULL - 1'b1);
                    st_d.cnt     = st_q.cnt + 1'b1;
                end else begin
                    st_d.cnt = CNT_OVER;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.o_valid;
    assign out_byte    = st_q.o_byte;
    assign out_field   = st_q.o_field;
    assign out_sol     = st_q.o_sol;
    assign out_eol     = st_q.o_eol;
    assign out_idx     = st_q.o_idx;
    assign out_phase   = st_q.o_idx[1:0];
    assign code_valid  = st_q.c_valid;
    assign code_field  = st_q.c_f;
    assign code_vblank = st_q.c_v;
    assign code_eol    = st_q.c_h;
    assign code_err    = st_q.c_err;
    assign line_err    = st_q.l_err;
    assign line_count  = st_q.line_cnt;

    // R4
    no_reserved_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_byte != 8'h00 && out_byte != 8'hFF));

    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sol && $past(out_valid)) |-> (out_idx == $past(out_idx) + 1'b1));

    // R6
    eol_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |=> !out_valid);

    // R7
    line_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |=> !line_err);

    // R3
    code_no_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid || code_err) |-> !out_valid);

    // R7
    line_err_on_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |-> code_valid);

endmodule

// File: rtl/vid_line_extract.sv
module vid_line_extract
    import vle_pkg::*;
#(
    parameter int LINE_BYTES = 1440,
    parameter int MAX_LINES  = 1023
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [7:0]                     in_byte,
    output logic                           out_valid,
    output logic [7:0]                     out_byte,
    output logic                           out_field,
    output logic                           out_sol,
    output logic                           out_eol,
    output logic [$clog2(LINE_BYTES)-1:0]  out_idx,
    output logic [1:0]                     out_phase,
    output logic                           code_valid,
    output logic                           code_field,
    output logic                           code_vblank,
    output logic                           code_eol,
    output logic                           code_err,
    output logic                           line_err,
    output logic [$clog2(MAX_LINES+1)-1:0] line_count
);

    logic       code_ok;
    logic       code_bad;
    vle_flags_t flags;

    vle_sync_detect u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .code_ok  (code_ok),
        .code_bad (code_bad),
        .flags    (flags)
    );

    vle_line_tracker #(
        .LINE_BYTES (LINE_BYTES),
        .MAX_LINES  (MAX_LINES)
    ) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .code_ok     (code_ok),
        .code_bad    (code_bad),
        .flags       (flags),
        .out_valid   (out_valid),
        .out_byte    (out_byte),
        .out_field   (out_field),
        .out_sol     (out_sol),
        .out_eol     (out_eol),
        .out_idx     (out_idx),
        .out_phase   (out_phase),
        .code_valid  (code_valid),
        .code_field  (code_field),
        .code_vblank (code_vblank),
        .code_eol    (code_eol),
        .code_err    (code_err),
        .line_err    (line_err),
        .line_count  (line_count)
    );

endmodule

// File: tb/vid_line_extract_bench.sv
module vid_line_extract_bench;

    localparam int L   = 16;
    localparam int ML  = 63;
    localparam int IW  = $clog2(L);
    localparam int LCW = $clog2(ML + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [7:0]     in_byte = 8'h00;
    logic           out_valid, out_field, out_sol, out_eol;
    logic [7:0]     out_byte;
    logic [IW-1:0]  out_idx;
    logic [1:0]     out_phase;
    logic           code_valid, code_field, code_vblank, code_eol, code_err, line_err;
    logic [LCW-1:0] line_count;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    vid_line_extract #(.LINE_BYTES(L), .MAX_LINES(ML)) u_vid_line_extract (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte), .out_field(out_field),
        .out_sol(out_sol), .out_eol(out_eol), .out_idx(out_idx), .out_phase(out_phase),
        .code_valid(code_valid), .code_field(code_field), .code_vblank(code_vblank),
        .code_eol(code_eol), .code_err(code_err), .line_err(line_err),
        .line_count(line_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // Present one valid byte; return after the edge that takes it
    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = b;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] code_byte(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic preamble();
        put(8'hFF); eq("R4 preamble not forwarded", out_valid, 0);
        put(8'h00); eq("R4 preamble not forwarded", out_valid, 0);
        put(8'h00); eq("R4 preamble not forwarded", out_valid, 0);
    endtask

    task automatic code(input bit f, input bit v, input bit h, input int exp_lerr, input int exp_lc);
        preamble();
        put(code_byte(f, v, h));
        eq("R1 code_valid", code_valid, 1);
        eq("R1 code_field", code_field, f);
        eq("R1 code_vblank", code_vblank, v);
        eq("R1 code_eol", code_eol, h);
        eq("R3 no payload on code", out_valid, 0);
        eq("R7 R8 line_err", line_err, exp_lerr);
        eq("R9 line_count", line_count, exp_lc);
    endtask

    task automatic pay(input logic [7:0] b, input int idx, input bit f);
        put(b);
        eq("R3 out_valid", out_valid, 1);
        eq("R3 out_byte", out_byte, b);
        eq("R3 out_field", out_field, f);
        eq("R5 out_idx", out_idx, idx);
        eq("R5 out_phase", out_phase, idx % 4);
        eq("R5 out_sol", out_sol, idx == 0);
        eq("R5 out_eol", out_eol, idx == L - 1);
    endtask

    task automatic send_line(input bit f, input int len, input int lc);
        code(f, 1'b0, 1'b0, 0, lc);
        for (int i = 0; i < len; i++) begin
            if (i < L) begin
                pay(8'h20 + 8'(i), i, f);
            end else begin
                put(8'h20 + 8'(i));
                eq("R6 excess byte dropped", out_valid, 0);
            end
        end
        code(f, 1'b0, 1'b1, (len != L) ? 1 : 0, lc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        eq("R9 reset line_count", line_count, 0);
        eq("R5 reset out_valid", out_valid, 0);
        eq("R7 reset line_err", line_err, 0);
        eq("R1 reset code_valid", code_valid, 0);

        // R4: blanking filler with no open line
        for (int i = 0; i < 4; i++) begin
            put(8'h80); eq("R4 filler 80", out_valid, 0);
            put(8'h10); eq("R4 filler 10", out_valid, 0);
        end

        // R5 R6 R7: length sweep in field 0
        for (int len = 0; len <= L + 3; len++) begin
            send_line(1'b0, len, len + 1);
        end

        // R3: blanking start code opens no line
        code(1'b0, 1'b1, 1'b0, 0, L + 4);
        for (int i = 0; i < 6; i++) begin
            put(8'h80 + 8'(i)); eq("R3 vblank no payload", out_valid, 0);
        end
        code(1'b0, 1'b1, 1'b1, 0, L + 4);

        // R4 R10: reserved bytes and idle gaps inside a line, split preamble
        code(1'b0, 1'b0, 1'b0, 0, L + 5);
        for (int i = 0; i < 8; i++) pay(8'h40 + 8'(i), i, 1'b0);
        put(8'h00); eq("R4 reserved 00 dropped", out_valid, 0);
        put(8'hFF); eq("R4 reserved FF dropped", out_valid, 0);
        idle(8'h77); eq("R10 idle ignored", out_valid, 0);
        for (int i = 8; i < L; i++) pay(8'h40 + 8'(i), i, 1'b0);
        put(8'hFF); idle(8'h00); put(8'h00); idle(8'h11); put(8'h00);
        put(code_byte(1'b0, 1'b0, 1'b1));
        eq("R10 split preamble detected", code_valid, 1);
        eq("R4 R7 no error with reserved dropped", line_err, 0);

        // R9: field change resets line count; sweep field 1
        for (int len = 0; len <= L + 3; len++) begin
            send_line(1'b1, len, len + 1);
        end

        // R2: protection failure
        preamble();
        put(8'hC6);
        eq("R2 code_err", code_err, 1);
        eq("R2 code rejected", code_valid, 0);
        for (int i = 0; i < 4; i++) begin
            put(8'h30); eq("R2 bad code opens no line", out_valid, 0);
        end
        preamble();
        put(8'h47);
        eq("R2 bit7 clear rejected", code_err, 1);
        eq("R2 line_count unchanged", line_count, L + 4);

        // R8: start code truncates an open line
        code(1'b1, 1'b0, 1'b0, 0, L + 5);
        for (int i = 0; i < 5; i++) pay(8'h60 + 8'(i), i, 1'b1);
        code(1'b1, 1'b0, 1'b0, 1, L + 6);
        for (int i = 0; i < L; i++) pay(8'h60 + 8'(i), i, 1'b1);
        code(1'b1, 1'b0, 1'b1, 0, L + 6);

        // R7: end code with no open line
        code(1'b1, 1'b0, 1'b1, 0, L + 6);

        // R9: field change on a line-opening code
        code(1'b0, 1'b0, 1'b0, 0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule